// File: doc/BRIEF.md
# Full-Width Multiply-Accumulate with Digit Carry

This block computes `a * b + c` for three unsigned operands of `WIDTH` bits (64 by default) and keeps the whole `2*WIDTH`-bit answer. The low half comes back as the result digit. The high half comes back as a carry digit, where a narrower unit would discard it. Operand `a` is the multiplicand, `b` the scalar multiplier and `c` an incoming carry digit. The sum can never exceed `2^(2*WIDTH) - 1`, so no overflow indication exists.

A host multiplies a multi-word vector by a scalar with a chain of these operations. It runs the words from least to most significant. The first word uses a carry of zero. Each later word takes the previous carry digit as its incoming carry. The carry digit from the last word becomes the top word of the product.

The product is formed by shift-and-add, one multiplier bit per clock. A one-cycle `start` captures the operands. A one-cycle `done` marks the moment the result appears.

Top module: `wide_mac`

## Requirements
- R1: When `done` is high, `resultLo` equals bits `[WIDTH-1:0]` of `multiplicand*multiplier + carryIn`, using the operands captured at the accepted start.
- R2: When `done` is high, `carryOut` equals bits `[2*WIDTH-1:WIDTH]` of that same sum.
- R3: A start is accepted when `start` is high at a rising edge while `busy` is low. `done` is high for exactly one cycle, and it rises at the `WIDTH`-th rising edge after the accepting edge.
- R4: `busy` is high from the edge that accepts a start up to the edge that raises `done`, and is never high together with `done`. `start` and operand changes while `busy` is high have no effect on the result.
- R5: `resultLo` and `carryOut` keep their values from one completion until the next one.
- R6: After reset, `busy`, `done`, `resultLo` and `carryOut` are all zero.
- R7: A chain of operations over the words of a vector computes the exact product with the scalar. The first carry-in is zero, each `carryOut` is fed to the next `carryIn`, and the final `carryOut` forms the most significant word.
- R8: With all three operands at their maximum value, the sum still fits: `resultLo` is zero and `carryOut` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when idle |
| multiplicand | input | WIDTH | Operand a |
| multiplier | input | WIDTH | Scalar operand b |
| carryIn | input | WIDTH | Incoming carry digit c |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resultLo | output | WIDTH | Low half of a*b+c |
| carryOut | output | WIDTH | High half of a*b+c |

## Verification
Each result is due exactly `WIDTH` rising edges after the edge that accepts `start`. `busy` rises at that accepting edge, and `done` and both result digits change together at the final edge. The bench keeps a behavioural model that counts down the same number of edges from each accepted start. It compares `busy`, `done` and both digits against that model on every falling edge, which covers the exact completion cycle and every cycle of holding in between. Starts issued mid-operation with junk operands, maximum operands and multi-word chains checked against a wide product test the rest of the requirements.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  // Strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic load;    // capture operands, seed accumulator with carry digit
    logic step;    // consume one multiplier bit
    logic finish;  // last step: publish both digits
  } wmac_strobe_t;
endpackage

// File: rtl/wmac_ctrl.sv
module wmac_ctrl
  import wmac_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output wmac_strobe_t strb,
  output logic         busy,
  output logic         done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] stepCnt;

  always_comb begin
    strb.load   = start && !busy;
    strb.step   = busy;
    strb.finish = busy && (stepCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (strb.finish) begin
        busy    <= 1'b0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R3
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R4
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> busy); // R4
endmodule

// File: rtl/wmac_dpath.sv
module wmac_dpath
  import wmac_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  wmac_strobe_t     strb,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  input  logic [WIDTH-1:0] carryIn,
  output logic [WIDTH-1:0] resultLo,
  output logic [WIDTH-1:0] carryOut
);
  localparam int DW = 2 * WIDTH;

  logic [DW-1:0]    mcand;    // multiplicand, moves left one bit per step
  logic [WIDTH-1:0] mplier;   // multiplier, moves right one bit per step
  logic [DW-1:0]    acc;
  logic [DW-1:0]    addend;
  logic [DW:0]      sumWide;
  logic [DW-1:0]    accNext;

  always_comb begin
    addend  = mplier[0] ? mcand : '0;
    sumWide = {1'b0, acc} + {1'b0, addend};
    accNext = sumWide[DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand    <= '0;
      mplier   <= '0;
      acc      <= '0;
      resultLo <= '0;
      carryOut <= '0;
    end else begin
      if (strb.load) begin
        mcand  <= DW'(multiplicand);
        mplier <= multiplier;
        acc    <= DW'(carryIn);
      end else if (strb.step) begin
        acc    <= accNext;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
      end
      if (strb.finish) begin
        resultLo <= accNext[WIDTH-1:0];
        carryOut <= accNext[DW-1:WIDTH];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> !sumWide[DW]); // R8
  AST_NO_LOAD_MID_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.step)); // R4
endmodule

// File: rtl/wide_mac.sv
module wide_mac
  import wmac_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  input  logic [WIDTH-1:0] carryIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] resultLo,
  output logic [WIDTH-1:0] carryOut
);
  wmac_strobe_t strb;

  wmac_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  wmac_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .carryIn      (carryIn),
    .resultLo     (resultLo),
    .carryOut     (carryOut)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(resultLo) && $stable(carryOut))); // R5
endmodule

// File: tb/test_wide_mac.sv
`timescale 1ns/1ps
module test_wide_mac;
  localparam int W = 64;
  localparam int WORDS = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] multiplicand = '0, multiplier = '0, carryIn = '0;
  logic         busy, done;
  logic [W-1:0] resultLo, carryOut;

  int errors = 0;
  int checks = 0;
  int cycle  = 0;
  bit monOn  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wide_mac #(.WIDTH(W)) i_wide_mac (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier), .carryIn(carryIn),
    .busy(busy), .done(done), .resultLo(resultLo), .carryOut(carryOut)
  );

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // Behavioural reference: counts edges from each accepted start
  bit           mBusy = 0, mDone = 0;
  int           mLeft = 0;
  logic [2*W-1:0] mPend = '0;
  logic [W-1:0] mLo = '0, mHi = '0;

  always @(posedge clk) begin
    cycle++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mLeft = 0; mLo = '0; mHi = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1;
          mLo = mPend[W-1:0]; mHi = mPend[2*W-1:W];
        end
      end else if (start) begin
        mBusy = 1; mLeft = W;
        mPend = {{W{1'b0}}, multiplicand} * {{W{1'b0}}, multiplier} + {{W{1'b0}}, carryIn};
      end
    end
  end

  always @(negedge clk) begin
    if (monOn && rstN) begin
      chk("R4 busy", {{(2*W-1){1'b0}}, busy}, {{(2*W-1){1'b0}}, mBusy});
      chk("R3 done", {{(2*W-1){1'b0}}, done}, {{(2*W-1){1'b0}}, mDone});
      chk(mDone ? "R1 resultLo" : "R5 resultLo hold", {{W{1'b0}}, resultLo}, {{W{1'b0}}, mLo});
      chk(mDone ? "R2 carryOut" : "R5 carryOut hold", {{W{1'b0}}, carryOut}, {{W{1'b0}}, mHi});
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycle > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  task automatic doOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                      input bit poke, output logic [W-1:0] lo, output logic [W-1:0] hi);
    logic [2*W-1:0] exp;
    exp = {{W{1'b0}}, a} * {{W{1'b0}}, b} + {{W{1'b0}}, c};
    @(negedge clk);
    start = 1; multiplicand = a; multiplier = b; carryIn = c;
    @(negedge clk);
    start = 0;
    multiplicand = ~a; multiplier = b ^ 64'h5a5a; carryIn = c + 1;
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1; multiplicand = {$urandom, $urandom}; multiplier = {$urandom, $urandom};
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    lo = resultLo; hi = carryOut;
    chk("R4 operands ignored while busy", {hi, lo}, exp);
  endtask

  initial begin
    logic [W-1:0] lo, hi;
    logic [W-1:0] vec [WORDS];
    logic [W*(WORDS+1)-1:0] ref_wide, got;
    logic [W-1:0] carry, s;

    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 busy", {{(2*W-1){1'b0}}, busy}, '0);
    chk("R6 done", {{(2*W-1){1'b0}}, done}, '0);
    chk("R6 outputs", {carryOut, resultLo}, '0);
    rstN = 1;
    monOn = 1;

    doOp(64'd3, 64'd5, 64'd7, 0, lo, hi);
    chk("R1 small", {{W{1'b0}}, lo}, 128'd22);
    doOp('1, '1, '1, 1, lo, hi);
    chk("R8 max operands low", {{W{1'b0}}, lo}, '0);
    chk("R8 max operands high", {{W{1'b0}}, hi}, {{W{1'b0}}, {W{1'b1}}});
    doOp('0, '1, 64'h1234, 0, lo, hi);
    chk("R2 zero multiplicand", {hi, lo}, 128'h1234);
    doOp(64'h8000_0000_0000_0000, 64'd2, 64'd0, 1, lo, hi);
    chk("R2 top bit carry", {hi, lo}, {64'd1, 64'd0});

    repeat (5) @(negedge clk);
    chk("R5 hold after idle", {carryOut, resultLo}, {hi, lo});

    for (int t = 0; t < 8; t++) begin
      s = (t == 0) ? '1 : {$urandom, $urandom};
      for (int i = 0; i < WORDS; i++)
        vec[i] = (t == 1) ? '1 : {$urandom, $urandom};
      ref_wide = '0;
      for (int i = WORDS - 1; i >= 0; i--)
        ref_wide = (ref_wide << W) | {{(W*WORDS){1'b0}}, vec[i]};
      ref_wide = ref_wide * {{(W*WORDS){1'b0}}, s};
      carry = '0;
      got = '0;
      for (int i = 0; i < WORDS; i++) begin
        doOp(vec[i], s, carry, (i == 1), lo, hi);
        got[i*W +: W] = lo;
        carry = hi;
      end
      got[WORDS*W +: W] = carry;
      checks++;
      if (got !== ref_wide) begin
        errors++;
        $display("FAIL R7 chained product: actual=%h expected=%h", got, ref_wide);
      end
    end

    repeat (4) @(negedge clk);
    monOn = 0;
    finishRun();
  end
endmodule